// File: doc/BRIEF.md
# Adaptive Cyclic Converter Estimate Engine

This block is the digital half of a cyclic analog-to-digital converter whose per-cycle gains and update weights are not restricted to powers of two. For each held input sample it runs a fixed number of refinement cycles, `CYCLES`. In every cycle it receives a short signed code from the coarse internal quantizer. It corrects that code for the part of the running estimate that the internal DAC cannot represent. It then adds a weighted copy of the corrected code to a long fixed-point estimate.

The running estimate is `EST_W` bits wide, two's complement, in units of one estimate LSB. Its upper `DAC_W` bits drive the internal DAC. The amplifier gain for the cycle in progress is presented on `gain_out`. The weights and gains come from a small table that is written through a per-cycle write port. They are computed off-chip.

A conversion begins with a start request while the block is idle. It ends with a one-cycle `done` pulse that carries the final estimate on `result`. The block does not keep a reset or status interface beyond these signals.

Top module: `acadc_estimator`

## Requirements
- R1: A `start` seen on a clock edge while idle clears the estimate to zero, sets the cycle index to 0 and raises `busy` in the following cycle (so `dac_code` reads 0).
- R2: On each edge where `busy` and `code_vld` are both high, the estimate becomes `est + floor(L_k * yc / 2^CORR_FRAC)`. Here k is the cycle index, L_k is the unsigned `COEF_W`-bit weight for that index, and the floor is an arithmetic shift.
- R3: The corrected code is `yc = code * 2^CORR_FRAC - C_k * delta`. Here `code` is the two's-complement `CODE_W`-bit input, C_k is the unsigned `GAIN_W`-bit gain for the index, and `delta` is the low `EST_W-DAC_W` bits of the current estimate read as a non-negative number.
- R4: `dac_code` always equals bits [EST_W-1 : EST_W-DAC_W] of the current estimate, i.e. the estimate shifted right arithmetically by `EST_W-DAC_W`.
- R5: `gain_out` equals the stored gain of the current cycle index. The index counts the updates since the last start and is 0 while idle.
- R6: The update with index `CYCLES-1` ends the conversion. In the next cycle `done` is high for exactly one cycle, `busy` is low, and `result` holds the final estimate until the next conversion finishes.
- R7: A `start` while `busy` is high has no effect on the index, the estimate or the conversion.
- R8: A `code_vld` while idle changes neither the estimate, `dac_code` nor `result`.
- R9: An update whose exact sum exceeds the `EST_W`-bit signed range yields the nearest limit (+2^(EST_W-1)-1 or -2^(EST_W-1)) instead of wrapping.
- R10: A write with `tbl_we` high stores `tbl_gain` and `tbl_coef` at index `tbl_addr`. Later conversions use the new values for that index only.
- R11: After reset, `busy`, `done`, `dac_code` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a conversion (honoured only when idle) |
| code_vld | input | 1 | Coarse code for the current cycle is valid |
| code | input | CODE_W | Signed coarse quantizer code |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | CNT_W | Cycle index to write |
| tbl_gain | input | GAIN_W | Amplifier gain C_k to store |
| tbl_coef | input | COEF_W | Update weight L_k to store |
| busy | output | 1 | Conversion in progress |
| gain_out | output | GAIN_W | Gain for the current cycle |
| dac_code | output | DAC_W | Truncated estimate for the internal DAC |
| done | output | 1 | One-cycle end-of-conversion pulse |
| result | output | EST_W | Final estimate of the last conversion |

## Verification
The low bits of the estimate never appear directly at the ports. They are, however, fed back through the correction term into every later update, so a wrong delta or weight shows up first as a `dac_code` mismatch one or two cycles later and always as a `result` error at `done`. A miscounted cycle index appears at once on `gain_out` and shifts the `done` pulse by whole cycles. A saturation fault shows up as a `result` with the wrong sign at the end of a conversion that is driven to full scale.

// File: rtl/acadc_pkg.sv
package acadc_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } conv_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/acadc_coef_table.sv
module acadc_coef_table #(
  parameter int CYCLES = 8,
  parameter int GAIN_W = 8,
  parameter int COEF_W = 16,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  wr_idx,
  input  logic [GAIN_W-1:0] wr_gain,
  input  logic [COEF_W-1:0] wr_coef,
  input  logic [CNT_W-1:0]  rd_idx,
  output logic [GAIN_W-1:0] rd_gain,
  output logic [COEF_W-1:0] rd_coef
);

  logic [GAIN_W-1:0] gain_mem [CYCLES];
  logic [COEF_W-1:0] coef_mem [CYCLES];

  // one storage row per conversion cycle, each with its own write strobe
  for (genvar i = 0; i < CYCLES; i++) begin : g_row
    logic row_we;
    assign row_we = wr_en && (wr_idx == CNT_W'(i));

    always_ff @(posedge clk) begin
      if (row_we) begin
        gain_mem[i] <= wr_gain;
        coef_mem[i] <= wr_coef;
      end
    end
  end

  assign rd_gain = gain_mem[rd_idx];
  assign rd_coef = coef_mem[rd_idx];

endmodule

// File: rtl/acadc_update.sv
module acadc_update
  import acadc_pkg::*;
#(
  parameter int EST_W     = 20,
  parameter int DAC_W     = 12,
  parameter int CODE_W    = 4,
  parameter int GAIN_W    = 8,
  parameter int COEF_W    = 16,
  parameter int CORR_FRAC = 8
) (
  input  logic signed [EST_W-1:0]  est,
  input  logic        [CODE_W-1:0] code,
  input  logic        [GAIN_W-1:0] gain,
  input  logic        [COEF_W-1:0] coef,
  output logic signed [EST_W-1:0]  est_nxt,
  output logic                     upd_neg
);

  localparam int DROP_W = EST_W - DAC_W;
  localparam int YC_W   = imax(CODE_W + CORR_FRAC, GAIN_W + DROP_W) + 2;
  localparam int PR_W   = COEF_W + 1 + YC_W;
  localparam int SUM_W  = imax(PR_W, EST_W) + 1;

  localparam logic signed [SUM_W-1:0] SAT_HI =
    SUM_W'((longint'(1) <<< (EST_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] SAT_LO = -SAT_HI - SUM_W'(1);

  logic        [DROP_W-1:0]        delta;
  logic signed [YC_W-1:0]          code_ext;
  logic signed [YC_W-1:0]          code_sc;
  logic signed [YC_W-1:0]          corr;
  logic signed [YC_W-1:0]          yc;
  logic signed [PR_W-1:0]          coef_s;
  logic signed [PR_W-1:0]          yc_s;
  logic signed [PR_W-1:0]          prod;
  logic signed [PR_W-1:0]          upd;
  logic signed [SUM_W-1:0]         sum;

  // truncation residue of the estimate, never negative
  assign delta    = est[DROP_W-1:0];

  // code scaled into the fractional grid, minus gain times residue
  assign code_ext = {{(YC_W-CODE_W){code[CODE_W-1]}}, code};
  assign code_sc  = code_ext <<< CORR_FRAC;
  assign corr     = YC_W'(gain * delta);
  assign yc       = code_sc - corr;

  // weight the corrected code and drop the fractional bits (floor)
  assign coef_s   = {{(PR_W-COEF_W){1'b0}}, coef};
  assign yc_s     = {{(PR_W-YC_W){yc[YC_W-1]}}, yc};
  assign prod     = coef_s * yc_s;
  assign upd      = prod >>> CORR_FRAC;
  assign upd_neg  = upd[PR_W-1];

  assign sum = {{(SUM_W-EST_W){est[EST_W-1]}}, est}
             + {{(SUM_W-PR_W){upd[PR_W-1]}}, upd};

  always_comb begin
    if (sum > SAT_HI) begin
      est_nxt = SAT_HI[EST_W-1:0];
    end else if (sum < SAT_LO) begin
      est_nxt = SAT_LO[EST_W-1:0];
    end else begin
      est_nxt = sum[EST_W-1:0];
    end
  end

endmodule

// File: rtl/acadc_seq.sv
module acadc_seq
  import acadc_pkg::*;
#(
  parameter int CYCLES = 8,
  parameter int CNT_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             code_vld,
  output logic             busy,
  output logic [CNT_W-1:0] cyc_idx,
  output logic             clr,
  output logic             step,
  output logic             last,
  output logic             done
);

  conv_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;

  always_comb begin
    clr     = (state_q == ST_IDLE) && start;
    step    = (state_q == ST_RUN) && code_vld;
    last    = step && (cnt_q == CNT_W'(CYCLES - 1));
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    if (clr) begin
      state_d = ST_RUN;
      cnt_d   = '0;
    end else if (step) begin
      if (last) begin
        state_d = ST_IDLE;
        cnt_d   = '0;
        done_d  = 1'b1;
      end else begin
        cnt_d   = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign busy    = (state_q == ST_RUN);
  assign cyc_idx = cnt_q;
  assign done    = done_q;

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (state_q == ST_IDLE));

  // R7
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) && start && !code_vld |=> $stable(cnt_q) && (state_q == ST_RUN));

endmodule

// File: rtl/acadc_estimator.sv
module acadc_estimator
  import acadc_pkg::*;
#(
  parameter int CYCLES    = 8,
  parameter int EST_W     = 20,
  parameter int DAC_W     = 12,
  parameter int CODE_W    = 4,
  parameter int GAIN_W    = 8,
  parameter int COEF_W    = 16,
  parameter int CORR_FRAC = 8,
  localparam int CNT_W    = imax(1, $clog2(CYCLES))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              code_vld,
  input  logic [CODE_W-1:0] code,
  input  logic              tbl_we,
  input  logic [CNT_W-1:0]  tbl_addr,
  input  logic [GAIN_W-1:0] tbl_gain,
  input  logic [COEF_W-1:0] tbl_coef,
  output logic              busy,
  output logic [GAIN_W-1:0] gain_out,
  output logic [DAC_W-1:0]  dac_code,
  output logic              done,
  output logic [EST_W-1:0]  result
);

  logic                    rst_meta_q, rst_n_int;
  logic [CNT_W-1:0]        cyc_idx;
  logic                    clr, step, last;
  logic [COEF_W-1:0]       coef_cur;
  logic signed [EST_W-1:0] est_q, est_d, est_upd;
  logic                    est_en;
  logic [EST_W-1:0]        result_q;
  logic                    upd_neg;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_int  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_int  <= rst_meta_q;
    end
  end

  acadc_seq #(
    .CYCLES (CYCLES),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .start    (start),
    .code_vld (code_vld),
    .busy     (busy),
    .cyc_idx  (cyc_idx),
    .clr      (clr),
    .step     (step),
    .last     (last),
    .done     (done)
  );

  acadc_coef_table #(
    .CYCLES (CYCLES),
    .GAIN_W (GAIN_W),
    .COEF_W (COEF_W),
    .CNT_W  (CNT_W)
  ) u_table (
    .clk     (clk),
    .wr_en   (tbl_we),
    .wr_idx  (tbl_addr),
    .wr_gain (tbl_gain),
    .wr_coef (tbl_coef),
    .rd_idx  (cyc_idx),
    .rd_gain (gain_out),
    .rd_coef (coef_cur)
  );

  acadc_update #(
    .EST_W     (EST_W),
    .DAC_W     (DAC_W),
    .CODE_W    (CODE_W),
    .GAIN_W    (GAIN_W),
    .COEF_W    (COEF_W),
    .CORR_FRAC (CORR_FRAC)
  ) u_update (
    .est     (est_q),
    .code    (code),
    .gain    (gain_out),
    .coef    (coef_cur),
    .est_nxt (est_upd),
    .upd_neg (upd_neg)
  );

  // next-state of the estimate and its clock enable
  always_comb begin
    est_en = clr || step;
    est_d  = clr ? '0 : est_upd;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      est_q    <= '0;
      result_q <= '0;
    end else begin
      if (est_en) begin
        est_q <= est_d;
      end
      if (last) begin
        result_q <= est_upd;
      end
    end
  end

  assign dac_code = est_q[EST_W-1 -: DAC_W];
  assign result   = result_q;

  // R1
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !busy && start |=> busy && (dac_code == '0));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !busy && !start |=> $stable(est_q) && $stable(result_q));

  // R9
  sat_up_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    step && !upd_neg |=> est_q >= $past(est_q));

  // R9
  sat_down_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    step && upd_neg |=> est_q <= $past(est_q));

endmodule

// File: tb/acadc_estimator_bench.sv
module acadc_estimator_bench;

  localparam int CYCLES = 8;
  localparam int EST_W  = 20;
  localparam int DAC_W  = 12;
  localparam int CODE_W = 4;
  localparam int GAIN_W = 8;
  localparam int COEF_W = 16;
  localparam int CF     = 8;
  localparam int DROP_W = EST_W - DAC_W;
  localparam int CNT_W  = 3;
  localparam longint HI = (longint'(1) <<< (EST_W - 1)) - 1;
  localparam longint LO = -(longint'(1) <<< (EST_W - 1));

  // eight signed 4-bit codes per conversion, cycle k in bits [4k+3:4k]
  localparam int NVEC = 6;
  localparam logic [31:0] VEC [NVEC] = '{
    32'h0000_0003, 32'h7F1E_2D3C, 32'h8888_8888,
    32'h7777_7777, 32'hA5C3_E1F0, 32'h0F0F_0F0F
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              code_vld = 1'b0;
  logic [CODE_W-1:0] code = '0;
  logic              tbl_we = 1'b0;
  logic [CNT_W-1:0]  tbl_addr = '0;
  logic [GAIN_W-1:0] tbl_gain = '0;
  logic [COEF_W-1:0] tbl_coef = '0;
  logic              busy;
  logic [GAIN_W-1:0] gain_out;
  logic [DAC_W-1:0]  dac_code;
  logic              done;
  logic [EST_W-1:0]  result;

  int n_chk  = 0;
  int n_fail = 0;
  longint tg [CYCLES];
  longint tc [CYCLES];

  always #2 clk = ~clk;

  acadc_estimator u_acadc_estimator (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .code_vld (code_vld),
    .code     (code),
    .tbl_we   (tbl_we),
    .tbl_addr (tbl_addr),
    .tbl_gain (tbl_gain),
    .tbl_coef (tbl_coef),
    .busy     (busy),
    .gain_out (gain_out),
    .dac_code (dac_code),
    .done     (done),
    .result   (result)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint model_step(input longint e, input int y,
                                        input longint g, input longint c);
    longint delta, yc, s;
    delta = e & ((longint'(1) <<< DROP_W) - 1);
    yc    = longint'(y) * (longint'(1) <<< CF) - g * delta;
    s     = e + ((c * yc) >>> CF);
    if (s > HI) s = HI;
    if (s < LO) s = LO;
    return s;
  endfunction

  function automatic longint exp_dac(input longint e);
    return (e >>> DROP_W) & ((longint'(1) <<< DAC_W) - 1);
  endfunction

  function automatic int nib(input logic [31:0] v, input int k);
    logic [3:0] n;
    n = v[4*k +: 4];
    return int'($signed(n));
  endfunction

  task automatic wr_tbl(input int k, input longint g, input longint c);
    @(negedge clk);
    tbl_we   = 1'b1;
    tbl_addr = CNT_W'(k);
    tbl_gain = GAIN_W'(g);
    tbl_coef = COEF_W'(c);
    tg[k]    = g;
    tc[k]    = c;
    @(negedge clk);
    tbl_we   = 1'b0;
  endtask

  // full conversion; optional start pulse injected before cycle stall_at
  task automatic convert(input logic [31:0] v, input int stall_at);
    longint e;
    e = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1 busy", longint'(busy), 1);
    chk("R1 dac", longint'(dac_code), 0);
    for (int k = 0; k < CYCLES; k++) begin
      if (k == stall_at) begin
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R7 dac", longint'(dac_code), exp_dac(e));
        chk("R7 gain", longint'(gain_out), tg[k]);
      end
      code     = CODE_W'(nib(v, k));
      code_vld = 1'b1;
      chk("R5 gain", longint'(gain_out), tg[k]);
      chk("R4 dac", longint'(dac_code), exp_dac(e));
      e = model_step(e, nib(v, k), tg[k], tc[k]);
      @(negedge clk);
      code_vld = 1'b0;
    end
    chk("R6 done", longint'(done), 1);
    chk("R6 busy", longint'(busy), 0);
    chk("R2 R3 result", longint'($signed(result)), e);
    @(negedge clk);
    chk("R6 pulse", longint'(done), 0);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    longint sres;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 busy", longint'(busy), 0);
    chk("R11 done", longint'(done), 0);
    chk("R11 dac", longint'(dac_code), 0);
    chk("R11 result", longint'(result), 0);

    for (int k = 0; k < CYCLES; k++) begin
      wr_tbl(k, (k == 7) ? 255 : (3 <<< k), 24000 >>> k);
    end

    for (int i = 0; i < NVEC; i++) begin
      convert(VEC[i], -1);
    end

    // R7 start during a conversion
    convert(32'h3F2E_1D4C, 3);

    // R8 codes while idle
    sres = longint'($signed(result));
    @(negedge clk);
    code = 4'h7;
    code_vld = 1'b1;
    repeat (3) @(negedge clk);
    code_vld = 1'b0;
    chk("R8 result", longint'($signed(result)), sres);
    chk("R8 dac", longint'(dac_code), exp_dac(sres));
    chk("R8 busy", longint'(busy), 0);

    // R10 rewrite one table row
    wr_tbl(2, 17, 40001);
    convert(32'h1234_5671, -1);

    // R9 positive and negative saturation
    for (int k = 0; k < CYCLES; k++) wr_tbl(k, 1, 65535);
    convert(32'h7777_7777, -1);
    chk("R9 high", longint'($signed(result)), HI);
    convert(32'h8888_8888, -1);
    chk("R9 low", longint'($signed(result)), LO);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule